// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor with Lookahead Significand Adder

This block adds or subtracts two binary floating-point words and returns one floating-point word. The default format is single precision: a sign bit at the top, an 8-bit biased exponent below it (bias 127), and a 23-bit fraction in the low bits, with an implied leading one in front of the fraction. The exponent and fraction widths are parameters, so a narrow format can share the same datapath. An operation select chooses between a + b and a − b.

The work is split over three registered stages. The first stage decodes the fields, orders the operands by magnitude, and shifts the smaller significand right so that both exponents match. It keeps guard, round and sticky bits during that shift. The second stage forms the significand sum or difference in a two-level carry-lookahead network that is built from per-bit generate (AND) and propagate (OR) terms. The third stage normalizes the result, rounds it to nearest-even, detects overflow and underflow, and repacks the fields. A valid bit moves alongside the data, and a new operand pair may enter on every clock.

Top module: `fadd_cla`

## Requirements
- R1: The sign is at bit EXP_W+FRAC_W, the exponent at bits EXP_W+FRAC_W-1 down to FRAC_W, and the fraction at bits FRAC_W-1 down to 0. An operand whose exponent field is zero counts as zero, whatever its fraction holds. An all-ones input exponent is decoded as an ordinary finite exponent.
- R2: When the effective signs agree (sub_i=0 with equal signs, or sub_i=1 with opposite signs), the result is the exact sum of the magnitudes, rounded to FRAC_W fraction bits by round-to-nearest with ties to even, and it carries the common sign.
- R3: With sub_i=1 the sign of b is inverted before anything else. When the effective signs differ, the smaller magnitude is taken from the larger one, the result is rounded to nearest-even, and the result takes the sign of the larger magnitude.
- R4: A result that is exactly zero is output as +0 (all bits zero) with ovf_o low. This covers equal magnitudes that cancel and two zero operands.
- R5: A nonzero result whose magnitude lies below the smallest normal number is flushed to +0 with ovf_o low. No output ever has a zero exponent field together with a nonzero sign or fraction.
- R6: When the exponent after rounding would be all ones or larger, the output is the sign, an all-ones exponent and a zero fraction, and ovf_o is high. Otherwise ovf_o is low.
- R7: An operand pair presented with in_valid_i high at a rising edge appears on sum_o/ovf_o three rising edges later, with out_valid_o high. out_valid_o copies in_valid_i delayed by three edges. A new pair is accepted on every cycle.
- R8: While rst_ni is low, out_valid_o, sum_o and ovf_o are all zero.
- R9: Inputs sampled with in_valid_i low have no effect. On any cycle where out_valid_o is low, sum_o and ovf_o keep the values they held before.
- R10: The significand sum is formed by a lookahead carry network whose carry-out and sum equal x + y + carry-in. A carry out of the top significand bit shifts the result right by one place and increments the exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair on a_i/b_i/sub_i is valid |
| sub_i | input | 1 | 0: a + b, 1: a − b |
| a_i | input | 1+EXP_W+FRAC_W | First operand |
| b_i | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid_o | output | 1 | sum_o/ovf_o carry a new result |
| sum_o | output | 1+EXP_W+FRAC_W | Rounded result word |
| ovf_o | output | 1 | Result exponent overflowed |

## Verification
The bench uses a 4-bit exponent and 3-bit fraction so that it can sweep every operand pair under both operations. It compares each result with a value computed from exact integer arithmetic. The sweep reaches rounding ties that must go to even, and a design that always rounded up or always truncated would differ there. It also reaches additions with the same exponent that carry out of the significand, where a missing renormalize would return a doubled or halved value. Full cancellations must return +0 rather than a negative zero or leftover bits, near-cancellations below the smallest normal must be flushed and not emitted as denormals, and results at the top exponent must set the overflow flag with the saturated encoding. Bubbles carrying junk operands are mixed into the stream. They show whether the output holds its value, whether valid is aligned, and whether a stage register loads when it should not.

// File: rtl/fadd_pkg.sv
`timescale 1ns/1ps
package fadd_pkg;
  localparam int unsigned DEF_EXP_W  = 8;
  localparam int unsigned DEF_FRAC_W = 23;
  localparam int unsigned GRS_W      = 3;  // guard, round, sticky
  localparam int unsigned CLA_GRP    = 4;  // bits per lookahead group
endpackage

// File: rtl/cla_add.sv
`timescale 1ns/1ps
module cla_add #(
  parameter  int unsigned W   = 8,
  localparam int unsigned GRP = fadd_pkg::CLA_GRP,
  localparam int unsigned NG  = (W + GRP - 1) / GRP
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W-1:0]  gen, prp, cry;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   grp_c;

  assign gen = x_i & y_i;
  assign prp = x_i | y_i;

  // second level: group carries expanded from group generate/propagate
  always_comb begin
    logic acc, prod;
    for (int j = 0; j <= NG; j++) begin
      prod = c_i;
      for (int m = 0; m < j; m++) prod = prod & grp_p[m];
      acc = prod;
      for (int k = 0; k < j; k++) begin
        prod = grp_g[k];
        for (int m = k + 1; m < j; m++) prod = prod & grp_p[m];
        acc = acc | prod;
      end
      grp_c[j] = acc;
    end
  end

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    localparam int unsigned LO = gi * GRP;
    localparam int unsigned GW = (LO + GRP > W) ? (W - LO) : GRP;
    logic [GW-1:0] gg, pp, cc;
    logic          gk;

    assign gg = gen[LO +: GW];
    assign pp = prp[LO +: GW];

    always_comb begin
      logic acc, prod;
      gk = 1'b0;
      for (int k = 0; k < GW; k++) begin
        prod = gg[k];
        for (int m = k + 1; m < GW; m++) prod = prod & pp[m];
        gk = gk | prod;
      end
      for (int j = 0; j < GW; j++) begin
        prod = grp_c[gi];
        for (int m = 0; m < j; m++) prod = prod & pp[m];
        acc = prod;
        for (int k = 0; k < j; k++) begin
          prod = gg[k];
          for (int m = k + 1; m < j; m++) prod = prod & pp[m];
          acc = acc | prod;
        end
        cc[j] = acc;
      end
    end

    assign grp_g[gi]     = gk;
    assign grp_p[gi]     = &pp;
    assign cry[LO +: GW] = cc;
  end

  assign s_o  = x_i ^ y_i ^ cry;
  assign co_o = grp_c[NG];
endmodule

// File: rtl/fadd_align.sv
`timescale 1ns/1ps
module fadd_align #(
  parameter  int unsigned EXP_W  = fadd_pkg::DEF_EXP_W,
  parameter  int unsigned FRAC_W = fadd_pkg::DEF_FRAC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W,
  localparam int unsigned XW     = FRAC_W + 1 + fadd_pkg::GRS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             sub_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic             eff_sub_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [XW-1:0]    big_o,
  output logic [XW-1:0]    small_o
);
  localparam int unsigned GW = fadd_pkg::GRS_W;

  logic [EXP_W-1:0] ea, eb, e_big, e_small, diff;
  logic             za, zb, sa, sb, a_big, sticky;
  logic [W-2:0]     ka, kb;
  logic [XW-1:0]    sig_a, sig_b, sig_big, sig_small, shifted, lost_mask;

  always_comb begin
    ea    = a_i[W-2:FRAC_W];
    eb    = b_i[W-2:FRAC_W];
    za    = (ea == '0);
    zb    = (eb == '0);
    ka    = za ? '0 : a_i[W-2:0];
    kb    = zb ? '0 : b_i[W-2:0];
    sig_a = za ? '0 : {1'b1, a_i[FRAC_W-1:0], {GW{1'b0}}};
    sig_b = zb ? '0 : {1'b1, b_i[FRAC_W-1:0], {GW{1'b0}}};
    sa    = a_i[W-1];
    sb    = b_i[W-1] ^ sub_i;
    a_big = (ka >= kb);

    e_big     = a_big ? ea : eb;
    e_small   = a_big ? eb : ea;
    sig_big   = a_big ? sig_a : sig_b;
    sig_small = a_big ? sig_b : sig_a;
    diff      = e_big - e_small;

    lost_mask = '1;
    if (32'(diff) >= XW) begin
      shifted = '0;
      sticky  = |sig_small;
    end else begin
      lost_mask = ~({XW{1'b1}} << diff);
      shifted   = sig_small >> diff;
      sticky    = |(sig_small & lost_mask);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sign_o    <= 1'b0;
      eff_sub_o <= 1'b0;
      exp_o     <= '0;
      big_o     <= '0;
      small_o   <= '0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        sign_o    <= a_big ? sa : sb;
        eff_sub_o <= sa ^ sb;
        exp_o     <= e_big;
        big_o     <= sig_big;
        small_o   <= {shifted[XW-1:1], shifted[0] | sticky};
      end
    end
  end
endmodule

// File: rtl/fadd_norm.sv
`timescale 1ns/1ps
module fadd_norm #(
  parameter  int unsigned EXP_W  = fadd_pkg::DEF_EXP_W,
  parameter  int unsigned FRAC_W = fadd_pkg::DEF_FRAC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W,
  localparam int unsigned WW     = FRAC_W + 2 + fadd_pkg::GRS_W,
  localparam int unsigned SIG_W  = FRAC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [WW-1:0]    sum_i,
  output logic             valid_o,
  output logic [W-1:0]     res_o,
  output logic             ovf_o
);
  localparam int unsigned EXT  = EXP_W + 2;
  localparam int unsigned LZ_W = $clog2(WW) + 1;

  logic [LZ_W-1:0]  lz;
  logic             found, uflow, up, ovf_n, is_zero;
  logic [WW-2:0]    m;
  logic [EXT-1:0]   e_in, e, e2;
  logic [SIG_W:0]   rnd;
  logic [FRAC_W-1:0] frac;
  logic [W-1:0]     res_n;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = int'(WW) - 2; i >= 0; i--) begin
      if (!found) begin
        if (sum_i[i]) found = 1'b1;
        else          lz    = lz + LZ_W'(1);
      end
    end

    e_in    = EXT'(exp_i);
    is_zero = (sum_i == '0);
    if (sum_i[WW-1]) begin
      m     = sum_i[WW-1:1];
      m[0]  = sum_i[1] | sum_i[0];
      e     = e_in + EXT'(1);
      uflow = 1'b0;
    end else begin
      m     = sum_i[WW-2:0] << lz;
      e     = e_in - EXT'(lz);
      uflow = (EXT'(lz) >= e_in);
    end

    // nearest-even: guard set and (round | sticky | lsb)
    up  = m[2] & (m[1] | m[0] | m[3]);
    rnd = {1'b0, m[WW-2:3]} + (SIG_W+1)'(up);
    if (rnd[SIG_W]) begin
      e2   = e + EXT'(1);
      frac = rnd[FRAC_W:1];
    end else begin
      e2   = e;
      frac = rnd[FRAC_W-1:0];
    end

    ovf_n = 1'b0;
    if (is_zero || uflow) begin
      res_n = '0;
    end else if (e2 >= EXT'({EXP_W{1'b1}})) begin
      res_n = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_n = 1'b1;
    end else begin
      res_n = {sign_i, e2[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_n;
        ovf_o <= ovf_n;
      end
    end
  end
endmodule

// File: rtl/fadd_cla.sv
`timescale 1ns/1ps
module fadd_cla #(
  parameter  int unsigned EXP_W  = fadd_pkg::DEF_EXP_W,
  parameter  int unsigned FRAC_W = fadd_pkg::DEF_FRAC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         out_valid_o,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam int unsigned XW = FRAC_W + 1 + fadd_pkg::GRS_W;
  localparam int unsigned WW = XW + 1;

  // stage 1: align
  logic             s1_valid, s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp;
  logic [XW-1:0]    s1_big, s1_small;

  fadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .sub_i      (sub_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .valid_o    (s1_valid),
    .sign_o     (s1_sign),
    .eff_sub_o  (s1_sub),
    .exp_o      (s1_exp),
    .big_o      (s1_big),
    .small_o    (s1_small)
  );

  // stage 2: significand add / subtract (two's complement for subtract)
  logic [WW-1:0] cla_x, cla_y, cla_s;
  logic          cla_c, cla_co;

  assign cla_x = {1'b0, s1_big};
  assign cla_y = s1_sub ? ~{1'b0, s1_small} : {1'b0, s1_small};
  assign cla_c = s1_sub;

  cla_add #(.W(WW)) u_cla (
    .x_i  (cla_x),
    .y_i  (cla_y),
    .c_i  (cla_c),
    .s_o  (cla_s),
    .co_o (cla_co)
  );

  logic             s2_valid, s2_sign;
  logic [EXP_W-1:0] s2_exp;
  logic [WW-1:0]    s2_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_sign  <= 1'b0;
      s2_exp   <= '0;
      s2_sum   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_sign <= s1_sign;
        s2_exp  <= s1_exp;
        s2_sum  <= cla_s;
      end
    end
  end

  // stage 3: normalize, round, pack
  fadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s2_valid),
    .sign_i  (s2_sign),
    .exp_i   (s2_exp),
    .sum_i   (s2_sum),
    .valid_o (out_valid_o),
    .res_o   (sum_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/fadd_cla_chk.sv
`timescale 1ns/1ps
module fadd_cla_chk #(
  parameter  int unsigned EXP_W  = fadd_pkg::DEF_EXP_W,
  parameter  int unsigned FRAC_W = fadd_pkg::DEF_FRAC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W,
  localparam int unsigned WW     = FRAC_W + 2 + fadd_pkg::GRS_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          out_valid_o,
  input logic [W-1:0]  sum_o,
  input logic          ovf_o,
  input logic [WW-1:0] add_x,
  input logic [WW-1:0] add_y,
  input logic          add_c,
  input logic [WW-1:0] add_s,
  input logic          add_co
);
  logic [1:0] warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_CLA_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {add_co, add_s} == ((WW+1)'(add_x) + (WW+1)'(add_y) + (WW+1)'(add_c))); // R10

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(sum_o) && $stable(ovf_o))); // R9

  AST_OVF_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ovf_o) |->
      (sum_o[W-2:FRAC_W] == '1 && sum_o[FRAC_W-1:0] == '0)); // R6

  AST_NO_SUBNORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && sum_o[W-2:FRAC_W] == '0) |-> (sum_o == '0 && !ovf_o)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && !ovf_o && sum_o == '0)); // R8
endmodule

bind fadd_cla fadd_cla_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .sum_o       (sum_o),
  .ovf_o       (ovf_o),
  .add_x       (cla_x),
  .add_y       (cla_y),
  .add_c       (cla_c),
  .add_s       (cla_s),
  .add_co      (cla_co)
);

// File: tb/fadd_cla_test.sv
`timescale 1ns/1ps
module fadd_cla_test;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int W  = 1 + EW + FW;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         in_valid_i = 1'b0;
  logic         sub_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         out_valid_o, ovf_o;
  logic [W-1:0] sum_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk_i = ~clk_i;

  fadd_cla #(.EXP_W(EW), .FRAC_W(FW)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .sub_i       (sub_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .sum_o       (sum_o),
    .ovf_o       (ovf_o)
  );

  // exact integer reference: returns {ovf, result word}
  function automatic logic [W:0] ref_op(logic [W-1:0] a, logic [W-1:0] b, logic s);
    int ma, mb, sum, m, p, sh, q, rem, half, e;
    logic neg;
    ma = (a[W-2:FW] == '0) ? 0 : (((1 << FW) | int'(a[FW-1:0])) << (int'(a[W-2:FW]) - 1));
    mb = (b[W-2:FW] == '0) ? 0 : (((1 << FW) | int'(b[FW-1:0])) << (int'(b[W-2:FW]) - 1));
    sum = (a[W-1] ? -ma : ma) + ((b[W-1] ^ s) ? -mb : mb);
    neg = (sum < 0);
    m   = neg ? -sum : sum;
    if (m == 0) return '0;
    p = 0;
    for (int i = 0; i < 31; i++) if (((m >> i) & 1) != 0) p = i;
    if (p < FW) return '0;
    sh = p - FW;
    q  = m >> sh;
    if (sh > 0) begin
      rem  = m & ((1 << sh) - 1);
      half = 1 << (sh - 1);
      if (rem > half || (rem == half && (q & 1) != 0)) q = q + 1;
    end
    if (q == (1 << (FW + 1))) begin
      q  = q >> 1;
      sh = sh + 1;
    end
    e = sh + 1;
    if (e >= (1 << EW) - 1) return {1'b1, neg, {EW{1'b1}}, {FW{1'b0}}};
    return {1'b0, neg, e[EW-1:0], q[FW-1:0]};
  endfunction

  function automatic string tag_of(logic [W-1:0] a, logic [W-1:0] b, logic s, logic [W:0] r);
    logic eff_add;
    eff_add = (a[W-1] == (b[W-1] ^ s));
    if (a[W-2:FW] == '0 || b[W-2:FW] == '0) return "R1";
    if (r == '0) return (!eff_add && a[W-2:0] == b[W-2:0]) ? "R4" : "R5";
    if (r[W]) return "R6";
    if (eff_add) return (a[W-2:FW] == b[W-2:FW]) ? "R10" : "R2";
    return "R3";
  endfunction

  logic [2:0]   h_v = '0;
  logic [W:0]   h_r [3];
  string        h_t [3];
  logic [W:0]   model = '0;

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic s);
    @(negedge clk_i);
    if (h_v[2]) model = h_r[2];
    n_chk++;
    if (out_valid_o !== h_v[2]) begin
      n_fail++;
      $display("FAIL R7: out_valid_o got %b expected %b", out_valid_o, h_v[2]);
    end
    n_chk++;
    if ({ovf_o, sum_o} !== model) begin
      n_fail++;
      $display("FAIL %s: {ovf,sum} got %h expected %h", h_v[2] ? h_t[2] : "R9",
               {ovf_o, sum_o}, model);
    end
    h_v[2] = h_v[1]; h_r[2] = h_r[1]; h_t[2] = h_t[1];
    h_v[1] = h_v[0]; h_r[1] = h_r[0]; h_t[1] = h_t[0];
    h_v[0] = v;
    h_r[0] = ref_op(a, b, s);
    h_t[0] = tag_of(a, b, s, h_r[0]);
    in_valid_i = v;
    a_i = a;
    b_i = b;
    sub_i = s;
  endtask

  initial begin
    int idx;
    for (int i = 0; i < 3; i++) begin
      h_r[i] = '0;
      h_t[i] = "R9";
    end
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (out_valid_o !== 1'b0 || sum_o !== '0 || ovf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: reset outputs got %b %h %b expected 0 0 0", out_valid_o, sum_o, ovf_o);
    end
    rst_ni = 1'b1;
    idx = 0;
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          idx++;
          if (idx % 61 == 0) step(1'b0, W'(b), W'(a ^ 8'h5a), 1'(~op)); // junk bubble, R9
          step(1'b1, W'(a), W'(b), 1'(op));
        end
      end
    end
    repeat (4) step(1'b0, '1, '1, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7: watchdog expired, got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule